// File: doc/BRIEF.md
# Command Register Lock Arbiter

This block guards a set of command registers that several bus masters share. Every bus access carries a privilege ID. A master claims the registers by reading the lock register. If that read finds the unit neither busy nor full, the master becomes the owner. The owner then writes the command fields and finishes with a commit write. The commit copies the fields into a four-entry shadow queue and frees the lock. Queued commands leave in order on a valid/ready outbound port.

An abandoned lock can be cleared by a clear-busy write. The write must name the current owner's privilege ID. The clear never touches queued commands. A separate flush, accepted only while the transfer engine signals an error, removes only the queued entries whose source matches the flushing master. The entries that remain keep their order. A small status register holds the completion code of the last release.

Register map (3-bit `addr_i`): 0..4 are the command fields, 5 is commit, 6 is the lock register and 7 is the status register. A lock read returns bit 0 = BSY and bit 1 = FULL. A lock-register write uses bit 16 = clear-busy, bit 17 = flush and bits [PID_W-1:0] = the target privilege ID of the clear. A status read returns the completion code in bits [2:0]. Read data is combinational and shows the state before the access takes effect.

Top module: `cmd_lock_arbiter`

## Requirements
- R1: The shadow queue holds four commands. A lock read returns FULL (bit 1) = 1 exactly when all four slots are occupied.
- R2: A lock read that finds BSY=0 and FULL=0 returns 0. It grants the lock to the reader, records the reader's `pid_i` as owner and sets BSY.
- R3: A lock read that finds FULL set returns FULL=1 and BSY=0 and grants nothing. A later read after a slot frees up can acquire the lock.
- R4: A lock read that finds BSY set and FULL clear returns BSY=1 and does not change the owner or the lock.
- R5: Writes to field registers 0..4, and commit writes, take effect only when `pid_i` equals the current owner while the lock is held. All others are dropped.
- R6: A commit write (address 5) by the owner appends {commit word, fields 4..0} with the owner's ID to the queue and clears BSY.
- R7: A lock-register write with bit 16 set releases the lock only when wdata bits [PID_W-1:0] equal the stored owner. A mismatching write has no effect.
- R8: A release by clear-busy sets the status code to 3'b111. A commit sets it to 3'b000. The reset value is 3'b000.
- R9: Clear-busy never removes entries that are already queued.
- R10: A lock-register write with bit 17 set removes the queued entries whose ID equals the writer's `pid_i`, but only while `err_i` is high. The entries that remain keep their order. With `err_i` low the write is ignored.
- R11: The oldest entry is presented on `out_data_o` and `out_pid_o` with `out_valid_o`. One entry is removed per cycle in which `out_valid_o` and `out_ready_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | DATA_W | Write data |
| pid_i | input | PID_W | Privilege ID of the accessing master |
| rdata_o | output | DATA_W | Read data (combinational) |
| err_i | input | 1 | Transfer engine error state; enables flush |
| out_valid_o | output | 1 | Queue head valid |
| out_ready_i | input | 1 | Consumer ready |
| out_data_o | output | 6*DATA_W | Head command {commit word, field4..field0} |
| out_pid_o | output | PID_W | Source ID of the head command |

## Verification
The lock is exercised under four patterns:
- **Uncontended claim and commit.** This shows that a correct grant leads to exactly one queued command.
- **Contention from a second master.** This separates a read that is merely observed from one that wrongly steals ownership or lets foreign field writes and commits land.
- **Queue full, then one slot freed.** This distinguishes refusing a grant on FULL from granting after space returns.
- **Clear-busy with a wrong and then the right ID.** This separates ID-matched release from unconditional release, and shows that the 3'b111 code and the queued entries survive.

A mixed-source fill followed by a flush, with the error input first low and then high, tells a source-selective and order-preserving removal apart from clearing everything or ignoring the error gate. The scoreboard compares every outbound entry in order, so a dropped, duplicated or reordered command is caught.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int ADDR_W     = 3;
  localparam int NUM_FIELDS = 5;
  localparam logic [ADDR_W-1:0] ADDR_COMMIT = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_LOCK   = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 3'd7;
  localparam int CBUSY_BIT = 16;
  localparam int FLUSH_BIT = 17;
  localparam logic [2:0] CC_DONE    = 3'b000;
  localparam logic [2:0] CC_CLEARED = 3'b111;
endpackage

// File: rtl/cla_lock_ctrl.sv
module cla_lock_ctrl #(
  parameter int PID_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_rd_i,
  input  logic             commit_wr_i,
  input  logic             cb_set_i,
  input  logic [PID_W-1:0] cb_pid_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic             full_i,
  output logic             busy_o,
  output logic             owner_match_o,
  output logic             commit_o,
  output logic [2:0]       code_o
);
  import cla_pkg::*;

  logic             busy_q;
  logic [PID_W-1:0] owner_q;
  logic [2:0]       code_q;
  logic             grant, cb_ok;

  assign owner_match_o = busy_q && (pid_i == owner_q);
  assign grant    = lock_rd_i && !busy_q && !full_i;
  assign commit_o = commit_wr_i && owner_match_o;
  assign cb_ok    = cb_set_i && busy_q && (cb_pid_i == owner_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      code_q  <= CC_DONE;
    end else begin
      if (grant) begin
        busy_q  <= 1'b1;
        owner_q <= pid_i;
      end else if (commit_o) begin
        busy_q <= 1'b0;
        code_q <= CC_DONE;
      end else if (cb_ok) begin
        busy_q <= 1'b0;
        code_q <= CC_CLEARED;
      end
    end
  end

  assign busy_o = busy_q;
  assign code_o = code_q;

  AST_GRANT_SETS_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant |=> (busy_q && owner_q == $past(pid_i))); // R2
  AST_FULL_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_rd_i && full_i && !busy_q) |=> !busy_q); // R3
  AST_BUSY_READ_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_rd_i && busy_q) |=> (busy_q && $stable(owner_q))); // R4
  AST_MISMATCH_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cb_set_i && busy_q && cb_pid_i != owner_q && !commit_o) |=> (busy_q && $stable(owner_q))); // R7
  AST_CB_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cb_ok && !commit_o) |=> (code_q == CC_CLEARED && !busy_q)); // R8
endmodule

// File: rtl/cla_shadow_queue.sv
module cla_shadow_queue #(
  parameter int PAY_W = 192,
  parameter int PID_W = 4,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [PAY_W-1:0] push_data_i,
  input  logic [PID_W-1:0] push_pid_i,
  input  logic             flush_i,
  input  logic [PID_W-1:0] flush_pid_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [PAY_W-1:0] head_data_o,
  output logic [PID_W-1:0] head_pid_o,
  output logic             full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PAY_W-1:0] data_q [DEPTH];
  logic [PID_W-1:0] pid_q  [DEPTH];
  logic [PAY_W-1:0] data_d [DEPTH];
  logic [PID_W-1:0] pid_d  [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pop;

  assign pop = ready_i && (cnt_q != '0);

  // compact survivors toward the head, then append
  always_comb begin
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DEPTH; i++) begin
      data_d[i] = data_q[i];
      pid_d[i]  = pid_q[i];
    end
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < cnt_q) && !(i == 0 && pop) && !(flush_i && pid_q[i] == flush_pid_i)) begin
        data_d[n[IDX_W-1:0]] = data_q[i];
        pid_d[n[IDX_W-1:0]]  = pid_q[i];
        n = n + 1'b1;
      end
    end
    if (push_i && n < CNT_W'(DEPTH)) begin
      data_d[n[IDX_W-1:0]] = push_data_i;
      pid_d[n[IDX_W-1:0]]  = push_pid_i;
      n = n + 1'b1;
    end
    cnt_d = n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      data_q[i] <= data_d[i];
      pid_q[i]  <= pid_d[i];
    end
  end

  assign valid_o     = (cnt_q != '0);
  assign head_data_o = data_q[0];
  assign head_pid_o  = pid_q[0];
  assign full_o      = (cnt_q == CNT_W'(DEPTH));
  assign count_o     = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CNT_W'(DEPTH))); // R1
  AST_POP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !push_i && !flush_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R11
endmodule

// File: rtl/cmd_lock_arbiter.sv
module cmd_lock_arbiter
  import cla_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PID_W  = 4,
  parameter int DEPTH  = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [2:0]                     addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [PID_W-1:0]               pid_i,
  output logic [DATA_W-1:0]              rdata_o,
  input  logic                           err_i,
  output logic                           out_valid_o,
  input  logic                           out_ready_i,
  output logic [(NUM_FIELDS+1)*DATA_W-1:0] out_data_o,
  output logic [PID_W-1:0]               out_pid_o
);
  localparam int PAY_W = (NUM_FIELDS + 1) * DATA_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              busy, owner_match, commit, full;
  logic [2:0]        code;
  logic              lock_rd, lock_wr, commit_wr, cb_set, flush;
  logic [PAY_W-1:0]  payload;
  logic [DATA_W-1:0] field_q [NUM_FIELDS];
  logic [CNT_W-1:0]  q_cnt;

  assign lock_rd   = req_i && !we_i && addr_i == ADDR_LOCK;
  assign lock_wr   = req_i && we_i && addr_i == ADDR_LOCK;
  assign commit_wr = req_i && we_i && addr_i == ADDR_COMMIT;
  assign cb_set    = lock_wr && wdata_i[CBUSY_BIT];
  assign flush     = lock_wr && wdata_i[FLUSH_BIT] && err_i;

  cla_lock_ctrl #(.PID_W(PID_W)) u_lock (
    .clk_i, .rst_ni,
    .lock_rd_i    (lock_rd),
    .commit_wr_i  (commit_wr),
    .cb_set_i     (cb_set),
    .cb_pid_i     (wdata_i[PID_W-1:0]),
    .pid_i        (pid_i),
    .full_i       (full),
    .busy_o       (busy),
    .owner_match_o(owner_match),
    .commit_o     (commit),
    .code_o       (code)
  );

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) field_q[g] <= '0;
      else if (req_i && we_i && addr_i == ADDR_W'(g) && owner_match) field_q[g] <= wdata_i;
    end
    assign payload[g*DATA_W +: DATA_W] = field_q[g];
  end
  assign payload[NUM_FIELDS*DATA_W +: DATA_W] = wdata_i;

  cla_shadow_queue #(.PAY_W(PAY_W), .PID_W(PID_W), .DEPTH(DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .push_i     (commit),
    .push_data_i(payload),
    .push_pid_i (pid_i),
    .flush_i    (flush),
    .flush_pid_i(pid_i),
    .ready_i    (out_ready_i),
    .valid_o    (out_valid_o),
    .head_data_o(out_data_o),
    .head_pid_o (out_pid_o),
    .full_o     (full),
    .count_o    (q_cnt)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (addr_i == ADDR_LOCK)      rdata_o[1:0] = {full, busy};
      else if (addr_i == ADDR_STAT) rdata_o[2:0] = code;
    end
  end

  AST_CB_KEEPS_QUEUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cb_set && !flush && !commit && !(out_valid_o && out_ready_i)) |=> (q_cnt == $past(q_cnt))); // R9
  AST_FLUSH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_wr && wdata_i[FLUSH_BIT] && !err_i && !(out_valid_o && out_ready_i)) |=> (q_cnt == $past(q_cnt))); // R10
  AST_COMMIT_PUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !out_ready_i) |=> (q_cnt == $past(q_cnt) + 1'b1 && !busy)); // R6
endmodule

// File: tb/cmd_lock_arbiter_tb_top.sv
module cmd_lock_arbiter_tb_top;
  localparam int DATA_W = 32;
  localparam int PID_W  = 4;
  localparam int PAY_W  = 6 * DATA_W;
  localparam int ENT_W  = PAY_W + PID_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, we = 0, err = 0, ready = 0;
  logic [2:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [PID_W-1:0] pid = '0;
  logic [DATA_W-1:0] rdata;
  logic out_valid;
  logic [PAY_W-1:0] out_data;
  logic [PID_W-1:0] out_pid;

  int tests = 0, fails = 0, drained = 0;
  bit done = 0;
  logic [ENT_W-1:0] exp_q[$];

  always #4 clk = ~clk;

  cmd_lock_arbiter #(.DATA_W(DATA_W), .PID_W(PID_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .pid_i(pid), .rdata_o(rdata), .err_i(err),
    .out_valid_o(out_valid), .out_ready_i(ready), .out_data_o(out_data), .out_pid_o(out_pid)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [DATA_W-1:0] d, input logic [PID_W-1:0] p);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; pid = p;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [PID_W-1:0] p, output logic [DATA_W-1:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a; pid = p;
    #1 d = rdata;
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic lock_rd_chk(input logic [PID_W-1:0] p, input logic [1:0] exp, input string tag);
    logic [DATA_W-1:0] d;
    bus_rd(3'd6, p, d);
    check(d[1:0] == exp, tag, d[1:0], exp);
  endtask

  task automatic stat_chk(input logic [2:0] exp, input string tag);
    logic [DATA_W-1:0] d;
    bus_rd(3'd7, 4'd0, d);
    check(d[2:0] == exp, tag, d[2:0], exp);
  endtask

  // acquire, program, commit; scoreboard push
  task automatic issue_cmd(input logic [PID_W-1:0] p, input logic [DATA_W-1:0] base);
    logic [PAY_W-1:0] pay;
    lock_rd_chk(p, 2'b00, "R2 grant read");
    for (int k = 0; k < 5; k++) begin
      bus_wr(3'(k), base + DATA_W'(k), p);
      pay[k*DATA_W +: DATA_W] = base + DATA_W'(k);
    end
    pay[5*DATA_W +: DATA_W] = base + 32'd5;
    bus_wr(3'd5, base + 32'd5, p);
    exp_q.push_back({pay, p});
  endtask

  task automatic cb_wr(input logic [PID_W-1:0] target, input logic [PID_W-1:0] p);
    bus_wr(3'd6, (32'h1 << 16) | DATA_W'(target), p);
  endtask

  // monitor: compare each handshake against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected output", 64'(out_pid), 64'hffff);
      end else begin
        logic [ENT_W-1:0] e;
        e = exp_q.pop_front();
        check(out_data == e[ENT_W-1:PID_W] && out_pid == e[PID_W-1:0],
              "R11 in-order payload/pid", 64'({out_data[PAY_W-1 -: 28], out_pid}),
              64'({e[ENT_W-1 -: 28], e[PID_W-1:0]}));
        drained++;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 reset valid", out_valid, 0);
    stat_chk(3'b000, "R8 reset code");

    // contention and ownership
    lock_rd_chk(4'd1, 2'b00, "R2 first claim");
    lock_rd_chk(4'd2, 2'b01, "R4 busy observed");
    for (int k = 0; k < 5; k++) bus_wr(3'(k), 32'hBAD0_0000, 4'd2);
    begin
      logic [PAY_W-1:0] pay;
      for (int k = 0; k < 5; k++) begin
        bus_wr(3'(k), 32'h1000 + 32'(k), 4'd1);
        pay[k*DATA_W +: DATA_W] = 32'h1000 + 32'(k);
      end
      bus_wr(3'd0, 32'hDEAD, 4'd2);          // R5 foreign write dropped
      bus_wr(3'd5, 32'hEEEE, 4'd2);          // R5 foreign commit dropped
      lock_rd_chk(4'd2, 2'b01, "R4 owner kept after foreign access");
      pay[5*DATA_W +: DATA_W] = 32'h1005;
      bus_wr(3'd5, 32'h1005, 4'd1);
      exp_q.push_back({pay, 4'd1});
    end
    @(negedge clk);
    check(out_valid == 1'b1, "R6 commit queued", out_valid, 1);
    stat_chk(3'b000, "R8 commit code");

    // fill to four
    issue_cmd(4'd1, 32'h2000);
    issue_cmd(4'd1, 32'h3000);
    issue_cmd(4'd1, 32'h4000);
    lock_rd_chk(4'd2, 2'b10, "R1 full flag");
    lock_rd_chk(4'd3, 2'b10, "R3 full read no grant");
    @(negedge clk); ready = 1;
    @(posedge clk); #1 ready = 0;
    lock_rd_chk(4'd3, 2'b00, "R3 grant after space");

    // clear-busy
    cb_wr(4'd2, 4'd5);
    lock_rd_chk(4'd2, 2'b01, "R7 mismatch ignored");
    stat_chk(3'b000, "R8 code unchanged by mismatch");
    cb_wr(4'd3, 4'd5);
    stat_chk(3'b111, "R8 clear code");
    lock_rd_chk(4'd4, 2'b00, "R7 released");
    cb_wr(4'd4, 4'd5);
    check(exp_q.size() == 3, "R9 queue depth kept", exp_q.size(), 3);
    ready = 1;
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    check(drained == 4 && !out_valid, "R9 all queued delivered", drained, 4);

    // flush
    ready = 0;
    issue_cmd(4'd1, 32'h5000);
    issue_cmd(4'd2, 32'h6000);
    issue_cmd(4'd1, 32'h7000);
    issue_cmd(4'd2, 32'h8000);
    bus_wr(3'd6, 32'h1 << 17, 4'd2);
    lock_rd_chk(4'd6, 2'b10, "R10 flush without error ignored");
    err = 1;
    bus_wr(3'd6, 32'h1 << 17, 4'd2);
    err = 0;
    begin
      logic [ENT_W-1:0] keep[$];
      foreach (exp_q[i]) if (exp_q[i][PID_W-1:0] != 4'd2) keep.push_back(exp_q[i]);
      exp_q = keep;
    end
    lock_rd_chk(4'd6, 2'b00, "R10 flush freed slots");
    cb_wr(4'd6, 4'd5);
    ready = 1;
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    check(drained == 6 && !out_valid, "R10 only matching source removed", drained, 6);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule